// File: doc/BRIEF.md
# Register-Bus Multiply-Accumulate Unit

This peripheral sits on a simple synchronous register bus and multiplies two operands, optionally adding the product into a running 32-bit sum. Software picks the arithmetic flavour by choosing which of four adjacent word addresses receives the first operand. Those flavours are: plain unsigned product, plain two's-complement product, unsigned accumulate and two's-complement accumulate. Writing the second operand launches the computation. A fixed number of clock cycles later, the result appears in a low-word register, a high-word register and an extension register. The extension register reports either a carry or a replicated sign, depending on the flavour.

Operands may be written as a full 16-bit word or as a single byte on the low lanes. A byte is widened by sign or by zeros according to the flavour. The three result registers can also be written from the bus. This lets software seed the accumulator before a chain of accumulate operations, or clear it. While a computation is in flight, a busy bit can be read, and the result registers keep their previous contents until the computation lands.

Top module: `mac_periph`

## Requirements
- R1: A write to word address 0, 1, 2 or 3 stores operand one and latches the flavour: 0 unsigned product, 1 signed product, 2 unsigned accumulate, 3 signed accumulate. A read of any of addresses 0–3 returns a status word with busy in bit 0, the latched flavour in bits 2:1 and zeros above.
- R2: A write to address 4 stores operand two and starts a computation with the stored operand one and the latched flavour. Operand one is retained, so repeated writes to address 4 reuse it.
- R3: The result registers take the new value on the third rising edge after the edge that captured the operand-two write. From that capture edge until the update edge, the busy bit reads 1 and the result registers read their previous contents.
- R4: The 32-bit result is read with bits 15..0 at address 5 and bits 31..16 at address 6. The extension register is at address 7.
- R5: In the unsigned-product flavour, the extension register becomes 0x0000 and the product replaces the result registers.
- R6: In both signed flavours, operands and result are two's complement and the signed-accumulate sum wraps modulo 2^32. The extension register becomes 0xFFFF if the 32-bit result is negative, and 0x0000 otherwise.
- R7: In the unsigned-accumulate flavour, the product is added to the result registers as they stand at the update edge. The extension register becomes 0x0001 on a carry out of bit 31, and 0x0000 otherwise.
- R8: With the byte strobe set, only write-data bits 7:0 are used. Operand one is sign-extended when written at address 1 or 3 and zero-extended at address 0 or 2. Operand two is sign-extended when the latched flavour is signed and zero-extended otherwise.
- R9: Addresses 5, 6 and 7 are writable. A byte write there zero-extends the low byte. A value written there serves as the accumulator for a later accumulate.
- R10: A bus write to a result register that is captured on the same edge as a computation's update is dropped, and the computed value is kept.
- R11: After reset, all registers read 0, the flavour is unsigned product and busy is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | 3 | Word address of the access |
| busWe | input | 1 | Write strobe for the current cycle |
| busByte | input | 1 | Byte write: only bits 7:0 of write data are used |
| busWData | input | 16 | Write data |
| busRData | output | 16 | Read data for busAddr, combinational |

## Verification
Two functions can land on the same clock edge: a software write to a result register, and the update from a computation that is finishing. The bench provokes this by timing a write to the low-word register so that it is captured exactly on the third edge after launch. It then reads the register back and expects the computed product, not the written value. It also writes the low word during the latency window. That write must show up immediately, while busy still reads 1, and must not be overwritten until the unsigned product lands.

// File: rtl/mac_pkg.sv
package mac_pkg;

  typedef enum logic [1:0] {
    MODE_MPY  = 2'd0,
    MODE_MPYS = 2'd1,
    MODE_MAC  = 2'd2,
    MODE_MACS = 2'd3
  } macMode_e;

  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] ADDR_OP2 = 3'd4;
  localparam logic [ADDR_W-1:0] ADDR_LO  = 3'd5;
  localparam logic [ADDR_W-1:0] ADDR_HI  = 3'd6;
  localparam logic [ADDR_W-1:0] ADDR_EXT = 3'd7;

  typedef struct packed {
    logic     ldOp1;
    logic     ldOp2;
    logic     loadSigned;
    logic     byteWr;
    logic     capProd;
    logic     finish;
    logic     wrLo;
    logic     wrHi;
    logic     wrExt;
    macMode_e mode;
  } ctlStrobe_t;

endpackage

// File: rtl/mac_ctrl.sv
module mac_ctrl
  import mac_pkg::*;
#(
  parameter int RES_LAT = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic              busByte,
  output ctlStrobe_t        strb,
  output logic              busy,
  output macMode_e          modeQ
);

  logic [RES_LAT-1:0] pipeQ;
  macMode_e           runModeQ;
  logic               isOp1;
  logic               isOp2;

  assign isOp1 = busWe && (busAddr[ADDR_W-1:2] == '0);
  assign isOp2 = busWe && (busAddr == ADDR_OP2);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ    <= MODE_MPY;
      runModeQ <= MODE_MPY;
      pipeQ    <= '0;
    end else begin
      if (isOp1) modeQ <= macMode_e'(busAddr[1:0]);
      if (isOp2) begin
        runModeQ <= modeQ;
        pipeQ    <= RES_LAT'(1);
      end else begin
        pipeQ <= {pipeQ[RES_LAT-2:0], 1'b0};
      end
    end
  end

  assign busy = |pipeQ;

  always_comb begin
    strb.ldOp1      = isOp1;
    strb.ldOp2      = isOp2;
    strb.loadSigned = isOp1 ? busAddr[0] : modeQ[0];
    strb.byteWr     = busByte;
    strb.capProd    = pipeQ[0];
    strb.finish     = pipeQ[RES_LAT-1];
    // completion owns the result registers on its edge
    strb.wrLo       = busWe && (busAddr == ADDR_LO)  && !pipeQ[RES_LAT-1];
    strb.wrHi       = busWe && (busAddr == ADDR_HI)  && !pipeQ[RES_LAT-1];
    strb.wrExt      = busWe && (busAddr == ADDR_EXT) && !pipeQ[RES_LAT-1];
    strb.mode       = runModeQ;
  end

endmodule

// File: rtl/mac_dpath.sv
module mac_dpath
  import mac_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strb,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWData,
  input  logic              busy,
  input  macMode_e          modeQ,
  output logic [DATA_W-1:0] busRData,
  output logic [DATA_W-1:0] resLo,
  output logic [DATA_W-1:0] resHi,
  output logic [DATA_W-1:0] resExt
);

  localparam int PW  = 2 * DATA_W;
  localparam int PAD = DATA_W - 8;

  logic [DATA_W-1:0] op1Q, op2Q;
  logic [DATA_W-1:0] opVal, rawVal, extNext;
  logic [PW-1:0]     prodQ, uProd, sProd, accIn;
  logic [PW:0]       sumW;

  assign opVal  = strb.byteWr ? {{PAD{strb.loadSigned & busWData[7]}}, busWData[7:0]} : busWData;
  assign rawVal = strb.byteWr ? {{PAD{1'b0}}, busWData[7:0]} : busWData;

  assign uProd = {{DATA_W{1'b0}}, op1Q} * {{DATA_W{1'b0}}, op2Q};
  assign sProd = {{DATA_W{op1Q[DATA_W-1]}}, op1Q} * {{DATA_W{op2Q[DATA_W-1]}}, op2Q};

  assign accIn = strb.mode[1] ? {resHi, resLo} : '0;
  assign sumW  = {1'b0, accIn} + {1'b0, prodQ};

  always_comb begin
    unique case (strb.mode)
      MODE_MPY:          extNext = '0;
      MODE_MAC:          extNext = {{(DATA_W-1){1'b0}}, sumW[PW]};
      MODE_MPYS, MODE_MACS: extNext = {DATA_W{sumW[PW-1]}};
      default:           extNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      op1Q   <= '0;
      op2Q   <= '0;
      prodQ  <= '0;
      resLo  <= '0;
      resHi  <= '0;
      resExt <= '0;
    end else begin
      if (strb.ldOp1) op1Q <= opVal;
      if (strb.ldOp2) op2Q <= opVal;
      if (strb.capProd) prodQ <= strb.mode[0] ? sProd : uProd;
      if (strb.finish) begin
        resLo  <= sumW[DATA_W-1:0];
        resHi  <= sumW[PW-1:DATA_W];
        resExt <= extNext;
      end else begin
        if (strb.wrLo)  resLo  <= rawVal;
        if (strb.wrHi)  resHi  <= rawVal;
        if (strb.wrExt) resExt <= rawVal;
      end
    end
  end

  always_comb begin
    unique case (busAddr)
      ADDR_OP2: busRData = op2Q;
      ADDR_LO:  busRData = resLo;
      ADDR_HI:  busRData = resHi;
      ADDR_EXT: busRData = resExt;
      default:  busRData = {{(DATA_W-3){1'b0}}, modeQ, busy};
    endcase
  end

endmodule

// File: rtl/mac_periph.sv
module mac_periph
  import mac_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int RES_LAT = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        busAddr,
  input  logic              busWe,
  input  logic              busByte,
  input  logic [DATA_W-1:0] busWData,
  output logic [DATA_W-1:0] busRData
);

  ctlStrobe_t        strb;
  logic              busy;
  macMode_e          modeQ;
  logic [DATA_W-1:0] resLo, resHi, resExt;

  mac_ctrl #(.RES_LAT(RES_LAT)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .busAddr (busAddr),
    .busWe   (busWe),
    .busByte (busByte),
    .strb    (strb),
    .busy    (busy),
    .modeQ   (modeQ)
  );

  mac_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .busAddr  (busAddr),
    .busWData (busWData),
    .busy     (busy),
    .modeQ    (modeQ),
    .busRData (busRData),
    .resLo    (resLo),
    .resHi    (resHi),
    .resExt   (resExt)
  );

endmodule

// File: rtl/mac_checker.sv
module mac_checker
  import mac_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              busWe,
  input logic [2:0]        busAddr,
  input logic              busy,
  input logic              finish,
  input macMode_e          runMode,
  input logic [DATA_W-1:0] resLo,
  input logic [DATA_W-1:0] resHi,
  input logic [DATA_W-1:0] resExt
);

  // R3: launch makes the unit busy on the next cycle
  a_r3_start_busy: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == ADDR_OP2) |=> busy);

  // R3: the update happens inside the busy window
  a_r3_finish_busy: assert property (@(posedge clk) disable iff (!rstN)
    finish |-> busy);

  // R3: busy only drops after an update
  a_r3_fall_done: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(finish));

  // R3, R10: low word holds while busy unless written by software
  a_r3_lo_hold: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !finish && !(busWe && busAddr == ADDR_LO)) |=> $stable(resLo));

  // R5: unsigned product clears the extension
  a_r5_ext_zero: assert property (@(posedge clk) disable iff (!rstN)
    (finish && runMode == MODE_MPY) |=> (resExt == '0));

  // R6: signed flavours replicate the result sign
  a_r6_sign_ext: assert property (@(posedge clk) disable iff (!rstN)
    (finish && runMode[0]) |=> (resExt == {DATA_W{resHi[DATA_W-1]}}));

  // R7: unsigned accumulate reports a single carry bit
  a_r7_carry_bit: assert property (@(posedge clk) disable iff (!rstN)
    (finish && runMode == MODE_MAC) |=> (resExt[DATA_W-1:1] == '0));

endmodule

bind mac_periph mac_checker #(.DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .busWe   (busWe),
  .busAddr (busAddr),
  .busy    (busy),
  .finish  (strb.finish),
  .runMode (strb.mode),
  .resLo   (resLo),
  .resHi   (resHi),
  .resExt  (resExt)
);

// File: tb/tb_mac_periph.sv
`timescale 1ns/100ps
module tb_mac_periph;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  busAddr = '0;
  logic        busWe = 1'b0;
  logic        busByte = 1'b0;
  logic [15:0] busWData = '0;
  logic [15:0] busRData;

  int nRun = 0;
  int nFail = 0;

  always #2 clk = ~clk;

  mac_periph dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busByte(busByte), .busWData(busWData), .busRData(busRData)
  );

  localparam int NV = 10;
  localparam logic [1:0]  V_MODE [NV] = '{2'd0, 2'd1, 2'd1, 2'd2, 2'd2, 2'd3, 2'd1, 2'd0, 2'd3, 2'd1};
  localparam logic [15:0] V_OP1  [NV] = '{16'hFFFF, 16'h8000, 16'hFFFF, 16'h0001, 16'h0003,
                                          16'hFFFE, 16'h0080, 16'h0080, 16'h0001, 16'h1234};
  localparam logic        V_B1   [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0};
  localparam logic [15:0] V_OP2  [NV] = '{16'hFFFF, 16'h8000, 16'h0001, 16'h0001, 16'h0004,
                                          16'h0003, 16'h0002, 16'h00FF, 16'h0001, 16'h00FE};
  localparam logic        V_B2   [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1};
  localparam logic [31:0] V_PRE  [NV] = '{32'h0, 32'h0, 32'h0, 32'hFFFFFFFF, 32'h00001000,
                                          32'h00000005, 32'h0, 32'h0, 32'h7FFFFFFF, 32'h0};

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d, input logic b = 1'b0);
    @(negedge clk);
    busWe = 1'b1; busAddr = a; busWData = d; busByte = b;
    @(negedge clk);
    busWe = 1'b0; busByte = 1'b0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [15:0] v);
    busAddr = a;
    #0.5;
    v = busRData;
  endtask

  function automatic logic [15:0] widen(input logic [15:0] d, input logic b, input logic s);
    if (!b) return d;
    return s ? {{8{d[7]}}, d[7:0]} : {8'h00, d[7:0]};
  endfunction

  function automatic logic [47:0] model(input logic [1:0] m, input logic [15:0] a,
                                        input logic [15:0] b, input logic [31:0] acc);
    logic [31:0] p;
    logic [32:0] s;
    logic [15:0] e;
    if (m[0]) p = 32'(int'($signed(a)) * int'($signed(b)));
    else      p = 32'(longint'(a) * longint'(b));
    s = {1'b0, (m[1] ? acc : 32'h0)} + {1'b0, p};
    if (m == 2'd0)      e = 16'h0;
    else if (m == 2'd2) e = {15'h0, s[32]};
    else                e = s[31] ? 16'hFFFF : 16'h0;
    return {e, s[31:0]};
  endfunction

  function automatic string reqOf(input logic [1:0] m);
    if (m == 2'd0) return "R5";
    if (m == 2'd2) return "R7";
    return "R6";
  endfunction

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    nRun++; nFail++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    logic [15:0] v, a1, a2;
    logic [47:0] exp;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R11 reset state
    peek(3'd5, v); chk("R11 lo", v, 16'h0);
    peek(3'd6, v); chk("R11 hi", v, 16'h0);
    peek(3'd7, v); chk("R11 ext", v, 16'h0);
    peek(3'd0, v); chk("R11 status", v, 16'h0);

    // R1 flavour latch seen in status bits 2:1
    wr(3'd3, 16'h0001); peek(3'd1, v); chk("R1 macs", v, 16'h0006);
    wr(3'd2, 16'h0001); peek(3'd0, v); chk("R1 mac", v, 16'h0004);

    // table: R4 word split, R5/R6/R7 flavours, R8 byte widening, R9 preload
    for (int i = 0; i < NV; i++) begin
      wr(3'd6, V_PRE[i][31:16]);
      wr(3'd5, V_PRE[i][15:0]);
      wr({1'b0, V_MODE[i]}, V_OP1[i], V_B1[i]);
      wr(3'd4, V_OP2[i], V_B2[i]);
      repeat (3) @(negedge clk);
      a1 = widen(V_OP1[i], V_B1[i], V_MODE[i][0]);
      a2 = widen(V_OP2[i], V_B2[i], V_MODE[i][0]);
      exp = model(V_MODE[i], a1, a2, V_PRE[i]);
      peek(3'd5, v); chk({reqOf(V_MODE[i]), " R4 lo"}, v, exp[15:0]);
      peek(3'd6, v); chk({reqOf(V_MODE[i]), " R4 hi"}, v, exp[31:16]);
      peek(3'd7, v); chk({reqOf(V_MODE[i]), " R8 ext"}, v, exp[47:32]);
    end

    // R3 latency window
    wr(3'd5, 16'h1111);
    wr(3'd0, 16'h0002);
    wr(3'd4, 16'h0003);
    peek(3'd0, v); chk("R3 busy c0", v, 16'h0001);
    peek(3'd5, v); chk("R3 old c0", v, 16'h1111);
    @(negedge clk);
    peek(3'd5, v); chk("R3 old c1", v, 16'h1111);
    @(negedge clk);
    peek(3'd0, v); chk("R3 busy c2", v, 16'h0001);
    peek(3'd5, v); chk("R3 old c2", v, 16'h1111);
    @(negedge clk);
    peek(3'd0, v); chk("R3 idle c3", v, 16'h0000);
    peek(3'd5, v); chk("R3 new c3", v, 16'h0006);

    // R2 operand one retained
    wr(3'd4, 16'h0005);
    repeat (3) @(negedge clk);
    peek(3'd5, v); chk("R2 reuse", v, 16'h000A);

    // R10 write captured on the update edge is dropped
    wr(3'd0, 16'h0004);
    wr(3'd4, 16'h0005);
    @(negedge clk);
    wr(3'd5, 16'hABCD);
    peek(3'd5, v); chk("R10 collide", v, 16'h0014);
    // R3, R10: a write inside the window (not on the update edge) lands
    wr(3'd4, 16'h0003);
    wr(3'd5, 16'h2222);
    peek(3'd0, v); chk("R3 busy mid", v, 16'h0001);
    peek(3'd5, v); chk("R10 mid write", v, 16'h2222);
    @(negedge clk);
    peek(3'd5, v); chk("R10 done", v, 16'h000C);

    // R9 byte write to result register zero-extends
    wr(3'd6, 16'hABFF, 1'b1); peek(3'd6, v); chk("R9 byte", v, 16'h00FF);
    wr(3'd7, 16'h1234);       peek(3'd7, v); chk("R9 ext", v, 16'h1234);

    // R7 accumulate chain producing carry
    wr(3'd5, 16'h0); wr(3'd6, 16'h0);
    wr(3'd2, 16'hFFFF);
    wr(3'd4, 16'hFFFF);
    repeat (3) @(negedge clk);
    peek(3'd7, v); chk("R7 first ext", v, 16'h0000);
    wr(3'd4, 16'hFFFF);
    repeat (3) @(negedge clk);
    peek(3'd5, v); chk("R7 chain lo", v, 16'h0002);
    peek(3'd6, v); chk("R7 chain hi", v, 16'hFFFC);
    peek(3'd7, v); chk("R7 chain carry", v, 16'h0001);

    summary();
  end

endmodule